// File: doc/BRIEF.md
# Shift-Chain Synchronous FIFO

This block is a single-clock FIFO whose storage is a chain of cells that physically move data. An accepted write shifts every cell one place toward the far end of the chain and drops the new word into the entry cell, so the oldest word always sits deepest in the chain. There is no RAM with two address counters. One up/down occupancy counter holds the fill level, and the tap it picks (fill level minus one) drives a combinational selector that presents the oldest word on the read port.

A mode input turns the same cells into a small read-only table. While it is high the chain holds still, the occupancy counter is frozen, and an external index selects the cell to present. Index 0 is the most recent accepted write and index k is the word written k writes earlier. A table is loaded by pushing its words in FIFO mode and then switching modes.

Top module: `shift_fifo`

## Requirements
- R1: After reset the count is 0, empty is high, full is low, the error output is low and read data is 0.
- R2: In FIFO mode, while empty is low, read data shows the oldest stored word in the same cycle, so words leave in the order they were accepted.
- R3: The count rises by one on an accepted write alone, falls by one on an accepted read alone, and is unchanged when both are accepted. Empty is high exactly at count 0 and full is high exactly at count 16, with 16 cells in the chain.
- R4: A write while full with no read in the same cycle is dropped: the chain and count do not change, and the error output is high in the next cycle.
- R5: A read while empty is dropped and the error output is high in the next cycle. A write in that same cycle is still accepted, which leaves the count at 1.
- R6: At full, a read and a write in the same cycle are both accepted. The oldest word is returned, the count stays 16 and the new word becomes the youngest.
- R7: While the table mode input is high, read data is the cell picked by the index input (0 = most recent accepted write). Push and pop are ignored, the count is unchanged and no error is raised.
- R8: In FIFO mode read data is 0 while empty is high.
- R9: The error output is high for exactly one cycle for each cycle with a dropped operation, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lut_mode_i | input | 1 | 1 = static table mode, 0 = FIFO mode |
| lut_idx_i | input | 4 | Cell index used in table mode |
| push_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| pop_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data (combinational) |
| full_o | output | 1 | Count equals 16 |
| empty_o | output | 1 | Count equals 0 |
| count_o | output | 5 | Number of stored words |
| err_o | output | 1 | One-cycle pulse after a dropped operation |

## Verification
The assertions check, on every cycle, the rules on the counter and error timing: the count bound, the step of the count after a lone accepted write, the hold of the count and the silent error line in table mode, the overflow and underflow pulses, and that full and empty never rise together. Data order cannot be seen from the counter. The bench shows it by checking every read word against a queue model under random push and pop traffic. That traffic includes simultaneous operations at full and at empty, and table-mode reads of each index against a history of accepted writes.

// File: rtl/shift_fifo_pkg.sv
package shift_fifo_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_PUSH = 2'b01,
    OP_POP  = 2'b10,
    OP_BOTH = 2'b11
  } op_e;
endpackage

// File: rtl/sf_cell_chain.sv
module sf_cell_chain #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  shift_i,
  input  logic [WIDTH-1:0]      din_i,
  output logic [DEPTH-1:0][WIDTH-1:0] cells_o
);
  logic [DEPTH-1:0][WIDTH-1:0] cell_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    if (g == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      cell_q[g] <= '0;
        else if (shift_i) cell_q[g] <= din_i;
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      cell_q[g] <= '0;
        else if (shift_i) cell_q[g] <= cell_q[g-1];
      end
    end
  end

  assign cells_o = cell_q;
endmodule

// File: rtl/sf_tap_mux.sv
module sf_tap_mux #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0][WIDTH-1:0] cells_i,
  input  logic [IW-1:0]               sel_i,
  output logic [WIDTH-1:0]            dout_o
);
  // and-or selector, one term per tap
  always_comb begin
    dout_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (sel_i == IW'(i)) dout_o = dout_o | cells_i[i];
    end
  end
endmodule

// File: rtl/sf_occ_ctrl.sv
module sf_occ_ctrl
  import shift_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lut_mode_i,
  input  logic          push_i,
  input  logic          pop_i,
  output logic          shift_o,
  output logic [IW-1:0] tap_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          err_o
);
  logic [CW-1:0] cnt_q, cnt_d, cnt_m1;
  logic          err_q, err_d;
  logic          pop_ok, push_ok;
  op_e           op;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));

  always_comb begin
    pop_ok  = 1'b0;
    push_ok = 1'b0;
    err_d   = 1'b0;
    if (!lut_mode_i) begin
      pop_ok  = pop_i && !empty_o;
      push_ok = push_i && (!full_o || pop_ok); // full: slot freed by same-cycle pop
      err_d   = (pop_i && !pop_ok) || (push_i && !push_ok);
    end
    op = op_e'({pop_ok, push_ok});
    unique case (op)
      OP_PUSH: cnt_d = cnt_q + CW'(1);
      OP_POP:  cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      err_q <= err_d;
    end
  end

  assign cnt_m1  = cnt_q - CW'(1);
  assign tap_o   = cnt_m1[IW-1:0];
  assign shift_o = push_ok;
  assign count_o = cnt_q;
  assign err_o   = err_q;

  assert_count_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH));
  assert_flags_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));
  assert_push_inc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lut_mode_i && push_i && !pop_i && !full_o) |=> (count_o == $past(count_o) + CW'(1)));
  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lut_mode_i && push_i && !pop_i && full_o) |=> (full_o && err_o));
  assert_no_underflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lut_mode_i && pop_i && empty_o) |=> err_o);
  assert_lut_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lut_mode_i |=> ($stable(count_o) && !err_o));
endmodule

// File: rtl/shift_fifo.sv
module shift_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lut_mode_i,
  input  logic [IW-1:0]    lut_idx_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [CW-1:0]    count_o,
  output logic             err_o
);
  logic [DEPTH-1:0][WIDTH-1:0] cells;
  logic                        shift;
  logic [IW-1:0]               tap, sel;
  logic [WIDTH-1:0]            mux_out;

  sf_occ_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i, .rst_ni, .lut_mode_i, .push_i, .pop_i,
    .shift_o(shift), .tap_o(tap), .count_o, .full_o, .empty_o, .err_o
  );

  sf_cell_chain #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chain (
    .clk_i, .rst_ni, .shift_i(shift), .din_i(wdata_i), .cells_o(cells)
  );

  assign sel = lut_mode_i ? lut_idx_i : tap;

  sf_tap_mux #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mux (
    .cells_i(cells), .sel_i(sel), .dout_o(mux_out)
  );

  assign rdata_o = (!lut_mode_i && empty_o) ? '0 : mux_out;

  assert_empty_no_err_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lut_mode_i && !push_i && !pop_i) |=> !err_o);
endmodule

// File: tb/shift_fifo_test.sv
module shift_fifo_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lut_mode = 1'b0;
  logic [3:0] lut_idx = '0;
  logic       push = 1'b0, pop = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       full, empty, err;
  logic [4:0] count;

  int n_tests = 0, n_fail = 0;
  logic [7:0] q[$];
  logic [7:0] hist[$];
  bit         exp_err = 1'b0;
  string      err_tag = "R9";

  always #5 clk = ~clk;

  shift_fifo uut (
    .clk_i(clk), .rst_ni(rst_n), .lut_mode_i(lut_mode), .lut_idx_i(lut_idx),
    .push_i(push), .wdata_i(wdata), .pop_i(pop), .rdata_o(rdata),
    .full_o(full), .empty_o(empty), .count_o(count), .err_o(err)
  );

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rdata(bit lm, logic [3:0] ix);
    if (lm) return hist[ix];
    if (q.size() == 0) return 8'h00;
    return q[0];
  endfunction

  task automatic step(bit ps, bit pp, logic [7:0] d, bit lm, logic [3:0] ix);
    bit pop_ok, push_ok;
    @(negedge clk);
    push = ps; pop = pp; wdata = d; lut_mode = lm; lut_idx = ix;
    #1;
    chk(lm ? "R7" : (q.size() == 0 ? "R8" : "R2"), rdata, exp_rdata(lm, ix));
    chk("R3 count", count, q.size());
    chk("R3 full", full, q.size() == 16);
    chk("R3 empty", empty, q.size() == 0);
    chk(err_tag, err, exp_err);
    exp_err = 1'b0; err_tag = "R9";
    if (!lm) begin
      pop_ok  = pp && q.size() > 0;
      push_ok = ps && (q.size() < 16 || pop_ok);
      if (pp && !pop_ok) begin exp_err = 1'b1; err_tag = "R5"; end
      if (ps && !push_ok) begin exp_err = 1'b1; err_tag = "R4"; end
      if (pop_ok) void'(q.pop_front());
      if (push_ok) begin
        q.push_back(d);
        hist.push_front(d);
        void'(hist.pop_back());
      end
    end
  endtask

  initial begin
    #2_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < 16; i++) hist.push_back(8'h00);
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 err", err, 0);
    chk("R1 rdata", rdata, 0);
    rst_n = 1'b1;
    // R5 pop on empty
    step(0, 1, 8'h00, 0, 0);
    step(0, 0, 8'h00, 0, 0);
    // fill to full
    for (int i = 0; i < 16; i++) step(1, 0, 8'h10 + 8'(i), 0, 0);
    // R4 push when full, twice back to back then idle (R9)
    step(1, 0, 8'hEE, 0, 0);
    step(1, 0, 8'hEF, 0, 0);
    step(0, 0, 8'h00, 0, 0);
    // R6 push+pop at full
    for (int i = 0; i < 3; i++) step(1, 1, 8'hA0 + 8'(i), 0, 0);
    // R7 table reads with push/pop ignored
    for (int i = 0; i < 16; i++) step(i[0], i[1], 8'h55, 1, 4'(i));
    step(0, 0, 8'h00, 0, 0);
    // drain
    for (int i = 0; i < 16; i++) step(0, 1, 8'h00, 0, 0);
    // R5 push+pop at empty
    step(1, 1, 8'h77, 0, 0);
    step(0, 1, 8'h00, 0, 0);
    step(0, 0, 8'h00, 0, 0);
    // random traffic, bias toward full and empty phases
    for (int i = 0; i < 4000; i++) begin
      int bias = (i / 500) % 2;
      int r = $urandom_range(0, 99);
      bit ps = bias ? (r < 70) : (r < 30);
      bit pp = bias ? ($urandom_range(0, 99) < 30) : ($urandom_range(0, 99) < 70);
      bit lm = ($urandom_range(0, 99) < 5);
      step(ps, pp, 8'($urandom), lm, 4'($urandom));
    end
    step(0, 0, 8'h00, 0, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule